// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Pin Output

The block gathers event lines from many interrupt sources into one status register and drives a single external interrupt pin from it. A status bit is set on the rising edge of its source. It is always recorded, whether or not that source is enabled. A per-source enable register decides which status bits may drive the pin. A fixed group of non-maskable sources reaches the pin whatever their enable bits say.

Software clears flags through a set/clear write port. One strobe bit chooses between setting and clearing, and a mask selects the affected sources. The set direction lets software force interrupts for testing. A configuration input can also make a status read clear the bits it returns. A second configuration input selects the active level of the pin. The pin comes from a register, so it never glitches.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is held, and in the first cycle after it, the status register and the enable register read all zeros and the pin is at 0.
- R2: A status bit becomes 1 at the clock edge where its source is sampled 1 after being sampled 0. A source held high does not set its bit again once that bit has been cleared.
- R3: A status bit is recorded even when its enable bit is 0, and a masked bit that is not non-maskable leaves the pin inactive.
- R4: A write to the enable register (`en_wr`) loads `en_data` at the next edge. An enabled status bit asserts the pin one clock edge after the status bit becomes 1.
- R5: A set/clear write with `sc_set`=0 clears, at the next edge, every status bit whose `sc_mask` bit is 1.
- R6: A set/clear write with `sc_set`=1 sets, at the next edge, every status bit whose `sc_mask` bit is 1.
- R7: When a bit is set (by a source edge or a set write) and cleared in the same cycle, it ends up 1.
- R8: `rd_data` always shows the status from before any clear. With `cfg_clr_on_read`=1, a cycle with `rd_req`=1 clears exactly the bits that `rd_data` showed as 1 in that cycle. With `cfg_clr_on_read`=0, `rd_req` has no effect on the status.
- R9: The pin stays active for as long as any status bit that is enabled or non-maskable remains 1. It goes inactive one edge after the last such bit clears.
- R10: With `cfg_pin_active_high`=1 the active pin level is 1. With 0 the active level is 0 and the inactive level is 1. The pin takes the new level one edge after the configuration changes.
- R11: Source indices 0, 1 and 2 (the default `NMI_MASK`) are non-maskable and drive the pin with their enable bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | N_SRC | Source event lines, edge-detected |
| en_wr | input | 1 | Enable register write strobe |
| en_data | input | N_SRC | New enable value |
| sc_wr | input | 1 | Set/clear write strobe |
| sc_set | input | 1 | 1 = set masked bits, 0 = clear masked bits |
| sc_mask | input | N_SRC | Sources affected by the set/clear write |
| rd_req | input | 1 | Status read strobe |
| cfg_clr_on_read | input | 1 | 1 = a status read clears the bits it returns |
| cfg_pin_active_high | input | 1 | 1 = pin active high, 0 = active low |
| rd_data | output | N_SRC | Status value (before any clear in this cycle) |
| irq_pin | output | 1 | Registered external interrupt pin |

## Verification
Two pairs of events can fall in the same clock cycle. In the first, a source edge meets a clear: a clear write and a fresh source edge hit the same bit. In the second, a read in clear-on-read mode coincides with a new edge on a different bit. The bench provokes both by raising `src_evt` on the same cycle that it drives `sc_wr` or `rd_req`. A reference model applies set-over-clear. The scoreboard then checks that the fresh bit survives while only the bits returned by the read are cleared.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // rising edge of sampled lines
  function automatic logic [63:0] f_rise(input logic [63:0] cur, input logic [63:0] prev);
    return cur & ~prev;
  endfunction

  // status update: clear first, then set, so a set never loses to a clear
  function automatic logic [63:0] f_next_status(input logic [63:0] cur,
                                                input logic [63:0] set_v,
                                                input logic [63:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // physical pin level for a logical request
  function automatic logic f_pin_level(input logic active, input logic active_high);
    return active_high ? active : ~active;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  output logic [N_SRC-1:0] src_rise
);
  import irq_agg_pkg::*;

  localparam int PADW = 64 - N_SRC;

  logic [N_SRC-1:0] src_q;
  logic [63:0]      rise_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_evt;
  end

  assign rise_wide = f_rise({{PADW{1'b0}}, src_evt}, {{PADW{1'b0}}, src_q});
  assign src_rise  = rise_wide[N_SRC-1:0];

  // a line that rose cannot rise again on the following cycle
  assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rise != '0) |=> ((src_rise & $past(src_rise)) == '0));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_rise,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_data,
  input  logic             sc_wr,
  input  logic             sc_set,
  input  logic [N_SRC-1:0] sc_mask,
  input  logic             rd_req,
  input  logic             cfg_clr_on_read,
  output logic [N_SRC-1:0] status_q,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] set_vec,
  output logic [N_SRC-1:0] clr_vec
);
  import irq_agg_pkg::*;

  localparam int PADW = 64 - N_SRC;

  logic [N_SRC-1:0] sw_set;
  logic [N_SRC-1:0] sw_clr;
  logic [N_SRC-1:0] rd_clr;
  logic [63:0]      next_wide;

  assign sw_set  = (sc_wr &&  sc_set) ? sc_mask : '0;
  assign sw_clr  = (sc_wr && !sc_set) ? sc_mask : '0;
  assign rd_clr  = (rd_req && cfg_clr_on_read) ? status_q : '0;
  assign set_vec = src_rise | sw_set;
  assign clr_vec = sw_clr | rd_clr;

  assign next_wide = f_next_status({{PADW{1'b0}}, status_q},
                                   {{PADW{1'b0}}, set_vec},
                                   {{PADW{1'b0}}, clr_vec});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= next_wide[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_data;
  end

  assert_enable_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(en_data)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_wr && !sc_set && set_vec == '0) |=> ((status_q & $past(sc_mask)) == '0));

  assert_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_wr && sc_set) |=> ((status_q & $past(sc_mask)) == $past(sc_mask)));

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cfg_clr_on_read) |=>
      ((status_q & $past(status_q) & ~$past(set_vec)) == '0));

  assert_read_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cfg_clr_on_read && !sc_wr && src_rise == '0) |=> $stable(status_q));

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver #(
  parameter int               N_SRC    = 16,
  parameter logic [N_SRC-1:0] NMI_MASK = 'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] status_q,
  input  logic [N_SRC-1:0] en_q,
  input  logic             cfg_pin_active_high,
  output logic [N_SRC-1:0] pending,
  output logic             pin_any,
  output logic             irq_pin
);
  import irq_agg_pkg::*;

  logic [N_SRC-1:0] route;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_route
      if (NMI_MASK[i]) begin : g_nmi
        assign route[i] = 1'b1;
      end else begin : g_mask
        assign route[i] = en_q[i];
      end
    end
  endgenerate

  assign pending = status_q & route;
  assign pin_any = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pin <= 1'b0;
    else        irq_pin <= f_pin_level(pin_any, cfg_pin_active_high);
  end

  assert_pin_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_any |=> (irq_pin == $past(cfg_pin_active_high)));

  assert_pin_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_any |=> (irq_pin == !$past(cfg_pin_active_high)));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int               N_SRC    = 16,
  parameter logic [N_SRC-1:0] NMI_MASK = 'b111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_data,
  input  logic             sc_wr,
  input  logic             sc_set,
  input  logic [N_SRC-1:0] sc_mask,
  input  logic             rd_req,
  input  logic             cfg_clr_on_read,
  input  logic             cfg_pin_active_high,
  output logic [N_SRC-1:0] rd_data,
  output logic             irq_pin
);

  logic [N_SRC-1:0] src_rise;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] pending;
  logic             pin_any;

  irq_edge_detect #(.N_SRC(N_SRC)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_evt  (src_evt),
    .src_rise (src_rise)
  );

  irq_status_bank #(.N_SRC(N_SRC)) u_bank (
    .clk             (clk),
    .rst_n           (rst_n),
    .src_rise        (src_rise),
    .en_wr           (en_wr),
    .en_data         (en_data),
    .sc_wr           (sc_wr),
    .sc_set          (sc_set),
    .sc_mask         (sc_mask),
    .rd_req          (rd_req),
    .cfg_clr_on_read (cfg_clr_on_read),
    .status_q        (status_q),
    .en_q            (en_q),
    .set_vec         (set_vec),
    .clr_vec         (clr_vec)
  );

  irq_pin_driver #(.N_SRC(N_SRC), .NMI_MASK(NMI_MASK)) u_pin (
    .clk                 (clk),
    .rst_n               (rst_n),
    .status_q            (status_q),
    .en_q                (en_q),
    .cfg_pin_active_high (cfg_pin_active_high),
    .pending             (pending),
    .pin_any             (pin_any),
    .irq_pin             (irq_pin)
  );

  assign rd_data = status_q;

  // a latched non-maskable flag reaches the pin regardless of enable
  assert_nmi_reach_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & NMI_MASK) != '0) |=> (irq_pin == $past(cfg_pin_active_high)));

  // masked, non-NMI flags alone never assert the pin
  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & (en_q | NMI_MASK)) == '0) |=> (irq_pin == !$past(cfg_pin_active_high)));

  // cleared bits never come back without a set
  assert_clear_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

  localparam int  N      = 16;
  localparam time CLK_PD = 10;
  localparam logic [N-1:0] NMI = 'b111;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic         en_wr = 1'b0;
  logic [N-1:0] en_data = '0;
  logic         sc_wr = 1'b0;
  logic         sc_set = 1'b0;
  logic [N-1:0] sc_mask = '0;
  logic         rd_req = 1'b0;
  logic         cfg_cor = 1'b0;
  logic         cfg_hi = 1'b1;
  logic [N-1:0] rd_data;
  logic         irq_pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [N-1:0] st;
    logic         pin;
    string        tag;
  } exp_t;

  exp_t sb_q[$];

  // reference state
  logic [N-1:0] m_src_q = '0;
  logic [N-1:0] m_status = '0;
  logic [N-1:0] m_en = '0;

  always #(CLK_PD/2) clk = ~clk;

  irq_aggregator #(.N_SRC(N), .NMI_MASK(NMI)) dut_i (
    .clk                 (clk),
    .rst_n               (rst_n),
    .src_evt             (src_evt),
    .en_wr               (en_wr),
    .en_data             (en_data),
    .sc_wr               (sc_wr),
    .sc_set              (sc_set),
    .sc_mask             (sc_mask),
    .rd_req              (rd_req),
    .cfg_clr_on_read     (cfg_clr_on_read_w),
    .cfg_pin_active_high (cfg_hi),
    .rd_data             (rd_data),
    .irq_pin             (irq_pin)
  );

  logic cfg_clr_on_read_w;
  assign cfg_clr_on_read_w = cfg_cor;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model the edge, queue the expectation, then drop strobes
  task automatic cyc(input string tag);
    logic [N-1:0] rise, setv, clrv, nxt;
    logic any;
    exp_t e;
    if (rd_req) check({tag, " R8 rd_data"}, rd_data, m_status);
    rise = src_evt & ~m_src_q;
    setv = rise | ((sc_wr && sc_set) ? sc_mask : '0);
    clrv = ((sc_wr && !sc_set) ? sc_mask : '0) | ((rd_req && cfg_cor) ? m_status : '0);
    nxt  = (m_status & ~clrv) | setv;
    any  = |(m_status & (m_en | NMI));
    e.st  = nxt;
    e.pin = cfg_hi ? any : ~any;
    e.tag = tag;
    sb_q.push_back(e);
    m_status = nxt;
    m_src_q  = src_evt;
    if (en_wr) m_en = en_data;
    @(posedge clk);
    #2;
    en_wr = 1'b0; sc_wr = 1'b0; rd_req = 1'b0;
  endtask

  // monitor: pop and compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " status"}, rd_data, e.st);
        check({e.tag, " pin"}, {{(N-1){1'b0}}, irq_pin}, {{(N-1){1'b0}}, e.pin});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset status", rd_data, '0);
    check("R1 reset pin", {{(N-1){1'b0}}, irq_pin}, '0);
    rst_n = 1'b1;
    cyc("R1 first cycle");

    src_evt[5] = 1'b1;                      cyc("R3 masked latch");
    cyc("R3 masked idle");
    sc_wr = 1; sc_set = 0; sc_mask = 16'h0020; cyc("R5 clear bit5");
    cyc("R2 held level no reset");
    src_evt[5] = 1'b0;
    en_wr = 1; en_data = 16'h00A0;          cyc("R4 enable write");
    src_evt[5] = 1'b1;                      cyc("R4 edge enabled");
    cyc("R4 pin asserted");
    sc_wr = 1; sc_set = 1; sc_mask = 16'h0080; cyc("R6 force bit7");
    sc_wr = 1; sc_set = 0; sc_mask = 16'h0020; cyc("R9 clear bit5 pin holds");
    cyc("R9 pin still active");
    sc_wr = 1; sc_set = 0; sc_mask = 16'h0080; cyc("R9 clear last");
    cyc("R9 pin released");
    src_evt[9] = 1'b1;
    sc_wr = 1; sc_set = 0; sc_mask = 16'h0200; cyc("R7 edge vs clear");
    cyc("R7 bit kept");
    cfg_cor = 0; rd_req = 1;                cyc("R8 read no clear");
    cfg_cor = 1; rd_req = 1; src_evt[10] = 1'b1; cyc("R8 read clears returned");
    cyc("R8 after read");
    rd_req = 1;                             cyc("R8 read clears bit10");
    src_evt[1] = 1'b1;                      cyc("R11 nmi latch");
    cyc("R11 nmi pin");
    cfg_hi = 0;                             cyc("R10 active low");
    cyc("R10 active low hold");
    sc_wr = 1; sc_set = 0; sc_mask = '1;    cyc("R10 clear all");
    cyc("R10 inactive high");
    cfg_hi = 1;                             cyc("R10 back to high");
    cyc("R10 idle");
    cyc("drain");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule